// File: doc/BRIEF.md
# Tick Counter Real-Time Clock with Dual Alarms

This block is a memory-mapped real-time clock core. A prescaler divides the slow input clock by an even, programmable amount to form a tick, and a 32-bit counter advances by one on each tick, wrapping after its largest value. Two alarm compare registers and a once-per-second event each raise a sticky flag. Each flag has an enable bit, and the enabled flags together drive one interrupt line.

Software reaches every register over a simple synchronous bus that runs on the same clock as the counter. A write completes in one cycle. Read data is registered and appears in the cycle after the read strobe. With the default wiring the tick rate is clk / (2 × (DIV + 1)). A DIV of 1023 on a 32.768 kHz input gives sixteen ticks per second, and the low four counter bits then count sixteenths of a second. A clock-select register must hold the crystal code 0x3 for counting to happen, and a 32-bit scratch word keeps software state across resets of the rest of the system.

Top module: `rtc_core`

## Requirements
- R1: After reset every register reads 0 (counter, both alarms, status, divider, clock select, scratch) and `irq` is low.
- R2: While counting is enabled, ticks are exactly 2 × (DIV + 1) clock cycles apart, and the counter advances by one on each tick.
- R3: Counting happens only while the 2-bit clock-select register (offset 0x1C) holds 0x3. Any other value halts the prescaler and the counter. The register reads back its two bits, and higher bits are dropped.
- R4: The 32-bit counter (offset 0x00) wraps from 0xFFFFFFFF to 0. A bus write loads it, and a load takes priority over a tick in the same cycle.
- R5: A write to the divider register (offset 0x0C) restarts the prescaler from zero, so the next tick comes a full 2 × (DIV + 1) cycles after that write.
- R6: Alarm A (offset 0x04) sets status bit 0, and alarm B (offset 0x18) sets status bit 4. A flag sets only on the tick at which the counter becomes equal to that alarm value. A bus load of an equal value does not set it, and a flag that has been cleared does not set again while the counter stays equal.
- R7: The seconds flag, status bit 1, sets on the tick at which the low four counter bits become zero (this includes the wrap to 0).
- R8: In the status register (offset 0x08), writing 1 to a flag bit (0, 1 or 4) clears that flag, and writing 0 leaves it unchanged. The enables (bit 2 for alarm A, bit 3 for seconds, bit 6 for alarm B) are plain read/write bits. All other bits read 0 and ignore writes. If a flag sets and is cleared in the same cycle, the set wins.
- R9: `irq` is a register holding the OR, over the three events, of flag AND enable. It follows one cycle after that term changes and stays high until software clears the flags or drops the enables.
- R10: The scratch register (offset 0x40) is plain 32-bit read/write storage that the counting logic never changes.
- R11: The alarm registers read back what was written. The divider holds 16 bits. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow input clock (nominally 32.768 kHz), also the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| irq | output | 1 | Level interrupt, enabled flags ORed |

## Verification
The bench builds the block with its default widths but programs the divider only with values from 0 to 7. This makes tick periods of 2 to 16 cycles, so exact tick counts can be predicted arithmetically across a sweep of divider values and wait lengths. With such short periods, the bench can also land a bus write on a tick edge, restart the prescaler in the middle of a period, and clear a flag while the counter still equals its alarm. Wrap and seconds-boundary behaviour are reached by preloading the counter near 0xFFFFFFFF or just below a multiple of sixteen.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  // register byte offsets
  localparam int OFS_COUNT   = 'h00;
  localparam int OFS_ALM_A   = 'h04;
  localparam int OFS_STATUS  = 'h08;
  localparam int OFS_DIV     = 'h0C;
  localparam int OFS_ALM_B   = 'h18;
  localparam int OFS_CLKSEL  = 'h1C;
  localparam int OFS_SCRATCH = 'h40;

  // event indices
  localparam int NUM_ALM = 2;
  localparam int EV_SEC  = NUM_ALM;
  localparam int NUM_EVT = NUM_ALM + 1;

  localparam int SEL_W   = 2;
  localparam logic [SEL_W-1:0] SEL_RUN = 2'b11;

  function automatic int flag_bit(input int ev);
    case (ev)
      0:       return 0;
      1:       return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int en_bit(input int ev);
    case (ev)
      0:       return 2;
      1:       return 6;
      default: return 3;
    endcase
  endfunction

  function automatic int alm_ofs(input int idx);
    return (idx == 0) ? OFS_ALM_A : OFS_ALM_B;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] half_cnt;
  logic             phase;
  logic             at_end;

  assign at_end = (half_cnt == div);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      half_cnt <= '0;
      phase    <= 1'b0;
    end else if (at_end) begin
      half_cnt <= '0;
      phase    <= ~phase;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  // one tick per full period: second half-period ends
  assign tick = run && at_end && phase;
endmodule

// File: rtl/rtc_tick_counter.sv
`timescale 1ns/1ps
module rtc_tick_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_inc,
  output logic             step
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign count_inc = count + ONE;
  assign step      = tick && !load;

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= count_inc;
  end
endmodule

// File: rtl/rtc_event_flag.sv
`timescale 1ns/1ps
module rtc_event_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/rtc_alarm_unit.sv
`timescale 1ns/1ps
module rtc_alarm_unit #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             step,
  input  logic [CNT_W-1:0] count_inc,
  output logic [CNT_W-1:0] alarm_val,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (rst)     alarm_val <= '0;
    else if (wr) alarm_val <= wdata;
  end

  // match only when a tick carries the counter onto the value
  assign hit = step && (count_inc == alarm_val);
endmodule

// File: rtl/rtc_core.sv
`timescale 1ns/1ps
module rtc_core #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int DIV_W     = 16,
  parameter int SEC_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import rtc_pkg::*;

  localparam int CNT_W = DATA_W;

  // bus decode
  logic wr_en, rd_en;
  logic hit_cnt, hit_sts, hit_div, hit_sel, hit_scr;
  logic [NUM_ALM-1:0] hit_alm;

  assign wr_en   = bus_sel && bus_we;
  assign rd_en   = bus_sel && !bus_we;
  assign hit_cnt = (bus_addr == ADDR_W'(OFS_COUNT));
  assign hit_sts = (bus_addr == ADDR_W'(OFS_STATUS));
  assign hit_div = (bus_addr == ADDR_W'(OFS_DIV));
  assign hit_sel = (bus_addr == ADDR_W'(OFS_CLKSEL));
  assign hit_scr = (bus_addr == ADDR_W'(OFS_SCRATCH));

  logic cnt_load, div_wr, sel_wr, scr_wr, sts_wr;
  assign cnt_load = wr_en && hit_cnt;
  assign div_wr   = wr_en && hit_div;
  assign sel_wr   = wr_en && hit_sel;
  assign scr_wr   = wr_en && hit_scr;
  assign sts_wr   = wr_en && hit_sts;

  // configuration registers
  logic [DIV_W-1:0]  div_q;
  logic [SEL_W-1:0]  clk_sel_q;
  logic [DATA_W-1:0] scratch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      clk_sel_q <= '0;
      scratch_q <= '0;
    end else begin
      if (div_wr) div_q     <= bus_wdata[DIV_W-1:0];
      if (sel_wr) clk_sel_q <= bus_wdata[SEL_W-1:0];
      if (scr_wr) scratch_q <= bus_wdata;
    end
  end

  // time base
  logic             tick_w;
  logic             step_w;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_inc;

  rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .run     (clk_sel_q == SEL_RUN),
    .restart (div_wr),
    .div     (div_q),
    .tick    (tick_w)
  );

  rtc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_w),
    .load      (cnt_load),
    .load_val  (bus_wdata),
    .count     (count_q),
    .count_inc (count_inc),
    .step      (step_w)
  );

  // events: alarms then seconds
  logic [NUM_EVT-1:0] evt_set, evt_clr, evt_flag, evt_en;
  logic [CNT_W-1:0]   alm_val [NUM_ALM];

  for (genvar a = 0; a < NUM_ALM; a++) begin : g_alm
    assign hit_alm[a] = (bus_addr == ADDR_W'(alm_ofs(a)));
    rtc_alarm_unit #(.CNT_W(CNT_W)) u_alm (
      .clk       (clk),
      .rst       (rst),
      .wr        (wr_en && hit_alm[a]),
      .wdata     (bus_wdata),
      .step      (step_w),
      .count_inc (count_inc),
      .alarm_val (alm_val[a]),
      .hit       (evt_set[a])
    );
  end

  assign evt_set[EV_SEC] = step_w && (count_inc[SEC_SHIFT-1:0] == '0);

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    assign evt_clr[e] = sts_wr && bus_wdata[flag_bit(e)];
    rtc_event_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .set  (evt_set[e]),
      .clr  (evt_clr[e]),
      .flag (evt_flag[e])
    );
    always_ff @(posedge clk) begin
      if (rst)         evt_en[e] <= 1'b0;
      else if (sts_wr) evt_en[e] <= bus_wdata[en_bit(e)];
    end
  end

  // status image
  logic [DATA_W-1:0] status_img;
  always_comb begin
    status_img = '0;
    for (int e = 0; e < NUM_EVT; e++) begin
      status_img[flag_bit(e)] = evt_flag[e];
      status_img[en_bit(e)]   = evt_en[e];
    end
  end

  // read path
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_cnt)      rd_mux = count_q;
    else if (hit_sts) rd_mux = status_img;
    else if (hit_div) rd_mux = DATA_W'(div_q);
    else if (hit_sel) rd_mux = DATA_W'(clk_sel_q);
    else if (hit_scr) rd_mux = scratch_q;
    else begin
      for (int a = 0; a < NUM_ALM; a++)
        if (hit_alm[a]) rd_mux = alm_val[a];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(evt_flag & evt_en);
  end
endmodule

// File: rtl/rtc_core_chk.sv
`timescale 1ns/1ps
module rtc_core_chk #(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 2,
  parameter int NUM_EVT = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               tick_w,
  input logic               step_w,
  input logic               cnt_load,
  input logic               div_wr,
  input logic               scr_wr,
  input logic               sts_wr,
  input logic [CNT_W-1:0]   bus_wdata,
  input logic [CNT_W-1:0]   count_q,
  input logic [CNT_W-1:0]   scratch_q,
  input logic [SEL_W-1:0]   clk_sel_q,
  input logic [NUM_EVT-1:0] evt_set,
  input logic [NUM_EVT-1:0] evt_flag,
  input logic               irq
);
  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (step_w && count_q == '1) |=> (count_q == '0));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_w && !cnt_load) |=> $stable(count_q));

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick_w |=> !tick_w);

  // R3
  halt_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_sel_q != 2'b11) |-> !tick_w);

  // R5
  div_restart_chk: assert property (@(posedge clk) disable iff (rst)
    div_wr |=> !tick_w);

  // R8
  alarm_a_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && bus_wdata[0] && !evt_set[0]) |=> !evt_flag[0]);

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_flag == '0) |=> !irq);

  // R10
  scratch_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !scr_wr |=> $stable(scratch_q));
endmodule

bind rtc_core rtc_core_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .SEL_W  (rtc_pkg::SEL_W),
  .NUM_EVT(rtc_pkg::NUM_EVT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_w    (tick_w),
  .step_w    (step_w),
  .cnt_load  (cnt_load),
  .div_wr    (div_wr),
  .scr_wr    (scr_wr),
  .sts_wr    (sts_wr),
  .bus_wdata (bus_wdata),
  .count_q   (count_q),
  .scratch_q (scratch_q),
  .clk_sel_q (clk_sel_q),
  .evt_set   (evt_set),
  .evt_flag  (evt_flag),
  .irq       (irq)
);

// File: tb/rtc_core_test.sv
`timescale 1ns/1ps
module rtc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [7:0] A_CNT = 8'h00, A_ALA = 8'h04, A_STS = 8'h08,
                         A_DIV = 8'h0C, A_ALB = 8'h18, A_SEL = 8'h1C,
                         A_SCR = 8'h40;

  rtc_core uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input string what,
                        input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    brd(a, v);
    chk(req, what, v, exp);
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    chk("R1", "irq after reset", {31'b0, irq}, 32'h0);
    chk_rd("R1", "counter reset", A_CNT, 32'h0);
    chk_rd("R1", "alarm A reset", A_ALA, 32'h0);
    chk_rd("R1", "alarm B reset", A_ALB, 32'h0);
    chk_rd("R1", "status reset",  A_STS, 32'h0);
    chk_rd("R1", "divider reset", A_DIV, 32'h0);
    chk_rd("R1", "clksel reset",  A_SEL, 32'h0);
    chk_rd("R1", "scratch reset", A_SCR, 32'h0);

    // R3 halted while select is not 3
    waitn(20);
    chk_rd("R3", "no count with sel=0", A_CNT, 32'h0);
    bwr(A_SEL, 32'h2);
    waitn(20);
    chk_rd("R3", "no count with sel=2", A_CNT, 32'h0);
    bwr(A_SEL, 32'hFFFF_FFFF);
    chk_rd("R3", "clksel keeps 2 bits", A_SEL, 32'h3);
    bwr(A_SEL, 32'h1);
    chk_rd("R3", "clksel readback", A_SEL, 32'h1);

    // R11 readback and unmapped
    bwr(A_ALA, 32'h1234_5678);
    chk_rd("R11", "alarm A readback", A_ALA, 32'h1234_5678);
    bwr(A_ALB, 32'h9ABC_DEF0);
    chk_rd("R11", "alarm B readback", A_ALB, 32'h9ABC_DEF0);
    bwr(A_DIV, 32'hFFFF_0123);
    chk_rd("R11", "divider 16 bits", A_DIV, 32'h0000_0123);
    chk_rd("R11", "unmapped read", 8'h20, 32'h0);
    bwr(A_SCR, 32'hDEAD_BEEF);
    chk_rd("R10", "scratch readback", A_SCR, 32'hDEAD_BEEF);

    // R2 rate sweep: count after W cycles = floor(W / (2*(D+1)))
    for (int d = 0; d < 5; d++) begin
      int t;
      int wl [6];
      t = 2 * (d + 1);
      wl = '{0, 1, t - 1, t, 3 * t + 1, 37};
      for (int k = 0; k < 6; k++) begin
        bwr(A_SEL, 32'h0);
        bwr(A_CNT, 32'h0);
        bwr(A_DIV, 32'(d));
        bwr(A_SEL, 32'h3);
        waitn(wl[k]);
        brd(A_CNT, v);
        chk("R2", $sformatf("ticks div=%0d wait=%0d", d, wl[k]), v,
            32'(wl[k] / t));
      end
    end
    chk_rd("R10", "scratch untouched by counting", A_SCR, 32'hDEAD_BEEF);

    // R5 restart on divider write (period 8)
    bwr(A_SEL, 32'h0);
    bwr(A_CNT, 32'h0);
    bwr(A_DIV, 32'h3);
    bwr(A_SEL, 32'h3);
    waitn(5);
    bwr(A_DIV, 32'h3);
    waitn(7);
    chk_rd("R5", "no tick before full period after restart", A_CNT, 32'h0);
    chk_rd("R5", "tick one full period after restart", A_CNT, 32'h1);

    // R4 load wins over tick (period 2)
    bwr(A_SEL, 32'h0);
    bwr(A_CNT, 32'h0);
    bwr(A_DIV, 32'h0);
    bwr(A_SEL, 32'h3);
    waitn(1);
    bwr(A_CNT, 32'h100);
    chk_rd("R4", "load on tick edge wins", A_CNT, 32'h100);

    // R4 / R7 wrap
    bwr(A_SEL, 32'h0);
    bwr(A_STS, 32'h13);
    bwr(A_CNT, 32'hFFFF_FFFE);
    bwr(A_SEL, 32'h3);
    waitn(5);
    chk_rd("R4", "wrap to zero", A_CNT, 32'h0);
    chk_rd("R7", "seconds flag on wrap", A_STS, 32'h2);

    // R6 / R7 / R9 frozen scenario, period 4
    bwr(A_SEL, 32'h0);
    bwr(A_DIV, 32'h1);
    bwr(A_CNT, 32'h0D);
    bwr(A_ALA, 32'h0F);
    bwr(A_ALB, 32'h10);
    bwr(A_STS, 32'h17);
    bwr(A_SEL, 32'h3);
    waitn(11);
    bwr(A_SEL, 32'h0);
    chk_rd("R6", "counter after three ticks", A_CNT, 32'h10);
    chk_rd("R6", "alarm A, alarm B and seconds flags", A_STS, 32'h17);
    chk("R9", "irq from alarm A", {31'b0, irq}, 32'h1);

    // R8 write-one-to-clear and enables
    bwr(A_STS, 32'h05);
    chk_rd("R8", "clear alarm A only", A_STS, 32'h16);
    chk("R9", "irq drops after clear", {31'b0, irq}, 32'h0);
    bwr(A_STS, 32'h44);
    chk_rd("R8", "write zero keeps flags, enables set", A_STS, 32'h56);
    chk("R9", "irq from alarm B enable", {31'b0, irq}, 32'h1);
    bwr(A_STS, 32'h00);
    chk_rd("R8", "enables cleared, flags kept", A_STS, 32'h12);
    chk("R9", "irq low with enables off", {31'b0, irq}, 32'h0);
    bwr(A_STS, 32'h12);
    chk_rd("R8", "seconds and alarm B cleared", A_STS, 32'h0);
    bwr(A_STS, 32'hFFFF_FFA8);
    chk_rd("R8", "reserved bits ignored", A_STS, 32'h08);

    // R6 bus load equal to alarm does not set flag
    bwr(A_CNT, 32'h0F);
    chk_rd("R6", "load equal to alarm no flag", A_STS, 32'h08);

    // R6 / R9 no re-set while equal, period 16
    bwr(A_DIV, 32'h7);
    bwr(A_CNT, 32'h20);
    bwr(A_ALA, 32'h22);
    bwr(A_STS, 32'h17);
    bwr(A_SEL, 32'h3);
    waitn(33);
    chk("R9", "irq one cycle after alarm A", {31'b0, irq}, 32'h1);
    bwr(A_STS, 32'h05);
    chk_rd("R6", "cleared flag stays clear while equal", A_STS, 32'h04);
    chk("R9", "irq low after clear", {31'b0, irq}, 32'h0);
    chk_rd("R6", "counter still equal to alarm", A_CNT, 32'h22);

    finish_run();
  end
endmodule